// File: doc/BRIEF.md
# Auto-Increment PIO Memory Port

This block is a programmed-I/O loading port for a small embedded controller. A host fills an instruction store and a data store one 32-bit word at a time through a narrow register window. It never addresses memory directly. For each store it programs a control register with a byte offset and increment flags. It then pushes words through a data register, and the offset walks forward by one word per access when increment is enabled. Each data word is little-endian: bits 7:0 hold the byte at the lowest address.

The instruction store is split into 256-byte blocks. Each block carries a host-assigned virtual page tag and a secure attribute. The host writes a tag before the words of each block, normally the destination offset shifted right by 8 and then one higher per block. The first instruction word written after a tag write copies the tag into that word's block. It also copies the current secure flag. A metadata read register shows the tag, secure bit and valid bit of the block under the current offset, so loaded images can be verified.

Register access is a valid/ready request stream with a valid/ready response stream for reads. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Writes take effect at that edge. A read's response appears one cycle later and is held stable until `rsp_ready` is sampled high. No new request is accepted while a response is pending, so `req_ready` is simply the inverse of `rsp_valid`.

Top module: `pio_mem_port`

## Requirements
- R1: After reset both offsets and all flags read as 0, every block's metadata reads as invalid (0), `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write to a control register (address 0 for instruction, 4 for data) loads the offset from bits 15:0, with bits 1:0 forced to 0 and the value truncated to the store size. It also loads write-increment from bit 16, read-increment from bit 17 and (instruction only) secure from bit 18. Reading the register returns those same fields.
- R3: A write to a data register (address 2 instruction, 5 data) stores the word at the current offset. The offset then advances by 4 if write-increment is set, and is unchanged otherwise.
- R4: A read of a data register returns the word at the current offset. The offset then advances by 4 if read-increment is set, and is unchanged otherwise.
- R5: The offset wraps to 0 when it advances past the last word of its store.
- R6: A write to the tag register (address 1, bits 15:0) arms a capture. The next instruction-data write copies the tag and the current secure flag into the metadata of the block holding that word, marks the block valid and disarms the capture. Later data writes leave metadata unchanged.
- R7: A read of address 3 returns the metadata of the block under the current instruction offset: tag in bits 15:0, secure in bit 16, valid in bit 31, with all other bits 0.
- R8: The data store has no secure attribute: bit 18 of its control register reads as 0. Accesses to either store never move the other store's offset.
- R9: While a read response is pending, `req_ready` is 0. `rsp_valid` and `rsp_rdata` are held until `rsp_ready` is high.
- R10: Writes to addresses 3, 6 and 7 change nothing. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 3 | Register select |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read response data |

## Verification
The bench builds the block with its default sizes: a 2 KiB instruction store (eight 256-byte blocks), a 1 KiB data store and 16-bit tags. Eight blocks let a multi-block load run up to the top of the instruction store and wrap its offset back to 0. They also leave untagged blocks to confirm the valid bit. The smaller data store puts its own wrap point at a different offset, so the two offsets can be shown to move independently.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    REG_ICTRL = 3'd0,
    REG_ITAG  = 3'd1,
    REG_IDATA = 3'd2,
    REG_IMETA = 3'd3,
    REG_DCTRL = 3'd4,
    REG_DDATA = 3'd5
  } reg_sel_e;

  localparam int CTL_WINC   = 16;
  localparam int CTL_RINC   = 17;
  localparam int CTL_SEC    = 18;
  localparam int META_SEC   = 16;
  localparam int META_VLD   = 31;
  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/pio_offset_ctr.sv
module pio_offset_ctr #(
  parameter int OFF_W   = 11,
  parameter bit HAS_SEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [OFF_W-3:0] off_in,
  input  logic             winc_in,
  input  logic             rinc_in,
  input  logic             sec_in,
  input  logic             adv,
  output logic [OFF_W-1:0] off,
  output logic             wr_inc,
  output logic             rd_inc,
  output logic             secure
);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(pio_pkg::WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off    <= '0;
      wr_inc <= 1'b0;
      rd_inc <= 1'b0;
    end else if (ctrl_we) begin
      off    <= {off_in, 2'b00};
      wr_inc <= winc_in;
      rd_inc <= rinc_in;
    end else if (adv) begin
      off    <= off + STEP;
    end
  end

  generate
    if (HAS_SEC) begin : g_sec
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       secure <= 1'b0;
        else if (ctrl_we) secure <= sec_in;
      end
    end else begin : g_nosec
      logic unused_sec;
      assign unused_sec = sec_in;
      assign secure     = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pio_word_mem.sv
module pio_word_mem #(
  parameter int WORDS = 512,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/pio_tag_store.sv
module pio_tag_store #(
  parameter int BLOCKS = 8,
  parameter int TAG_W  = 16,
  parameter int BLK_W  = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_we,
  input  logic [TAG_W-1:0] tag_wdata,
  input  logic             word_we,
  input  logic [BLK_W-1:0] blk,
  input  logic             word_sec,
  output logic [TAG_W-1:0] tag_q,
  output logic [TAG_W-1:0] meta_tag,
  output logic             meta_sec,
  output logic             meta_vld
);
  logic             armed;
  logic [TAG_W-1:0] tags [BLOCKS];
  logic [BLOCKS-1:0] secs, vlds;
  logic             capture;

  assign capture = word_we && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tag_q <= '0;
    end else if (tag_we) begin
      armed <= 1'b1;
      tag_q <= tag_wdata;
    end else if (capture) begin
      armed <= 1'b0;
    end
  end

  generate
    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tags[b] <= '0;
          secs[b] <= 1'b0;
          vlds[b] <= 1'b0;
        end else if (capture && blk == BLK_W'(b)) begin
          tags[b] <= tag_q;
          secs[b] <= word_sec;
          vlds[b] <= 1'b1;
        end
      end
    end
  endgenerate

  assign meta_tag = tags[blk];
  assign meta_sec = secs[blk];
  assign meta_vld = vlds[blk];
endmodule

// File: rtl/pio_mem_port.sv
module pio_mem_port #(
  parameter int IMEM_BYTES  = 2048,
  parameter int DMEM_BYTES  = 1024,
  parameter int BLOCK_BYTES = 256,
  parameter int TAG_W       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata
);
  import pio_pkg::*;

  localparam int IOFF_W  = $clog2(IMEM_BYTES);
  localparam int DOFF_W  = $clog2(DMEM_BYTES);
  localparam int IWORDS  = IMEM_BYTES / WORD_BYTES;
  localparam int DWORDS  = DMEM_BYTES / WORD_BYTES;
  localparam int IBLOCKS = IMEM_BYTES / BLOCK_BYTES;
  localparam int BLK_SH  = $clog2(BLOCK_BYTES);
  localparam int BLK_W   = $clog2(IBLOCKS);

  logic     acc, wr, rd;
  reg_sel_e sel;
  assign req_ready = !rsp_valid;
  assign acc = req_valid && req_ready;
  assign wr  = acc && req_write;
  assign rd  = acc && !req_write;
  assign sel = reg_sel_e'(req_addr);

  logic i_ctrl_we, i_tag_we, i_dat_we, i_dat_rd, d_ctrl_we, d_dat_we, d_dat_rd;
  assign i_ctrl_we = wr && sel == REG_ICTRL;
  assign i_tag_we  = wr && sel == REG_ITAG;
  assign i_dat_we  = wr && sel == REG_IDATA;
  assign i_dat_rd  = rd && sel == REG_IDATA;
  assign d_ctrl_we = wr && sel == REG_DCTRL;
  assign d_dat_we  = wr && sel == REG_DDATA;
  assign d_dat_rd  = rd && sel == REG_DDATA;

  logic [IOFF_W-1:0] ioff;
  logic [DOFF_W-1:0] doff;
  logic i_winc, i_rinc, i_sec, d_winc, d_rinc, d_sec;
  logic i_adv, d_adv;
  assign i_adv = (i_dat_we && i_winc) || (i_dat_rd && i_rinc);
  assign d_adv = (d_dat_we && d_winc) || (d_dat_rd && d_rinc);

  pio_offset_ctr #(.OFF_W(IOFF_W), .HAS_SEC(1'b1)) u_ictr (
    .clk(clk), .rst_n(rst_n), .ctrl_we(i_ctrl_we),
    .off_in(req_wdata[IOFF_W-1:2]), .winc_in(req_wdata[CTL_WINC]),
    .rinc_in(req_wdata[CTL_RINC]), .sec_in(req_wdata[CTL_SEC]),
    .adv(i_adv), .off(ioff), .wr_inc(i_winc), .rd_inc(i_rinc), .secure(i_sec)
  );

  pio_offset_ctr #(.OFF_W(DOFF_W), .HAS_SEC(1'b0)) u_dctr (
    .clk(clk), .rst_n(rst_n), .ctrl_we(d_ctrl_we),
    .off_in(req_wdata[DOFF_W-1:2]), .winc_in(req_wdata[CTL_WINC]),
    .rinc_in(req_wdata[CTL_RINC]), .sec_in(req_wdata[CTL_SEC]),
    .adv(d_adv), .off(doff), .wr_inc(d_winc), .rd_inc(d_rinc), .secure(d_sec)
  );

  logic [31:0] i_word, d_word;

  pio_word_mem #(.WORDS(IWORDS)) u_imem (
    .clk(clk), .we(i_dat_we), .addr(ioff[IOFF_W-1:2]),
    .wdata(req_wdata), .rdata(i_word)
  );

  pio_word_mem #(.WORDS(DWORDS)) u_dmem (
    .clk(clk), .we(d_dat_we), .addr(doff[DOFF_W-1:2]),
    .wdata(req_wdata), .rdata(d_word)
  );

  logic [TAG_W-1:0] tag_q, meta_tag;
  logic meta_sec, meta_vld;

  pio_tag_store #(.BLOCKS(IBLOCKS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .tag_we(i_tag_we), .tag_wdata(req_wdata[TAG_W-1:0]),
    .word_we(i_dat_we), .blk(ioff[IOFF_W-1:BLK_SH]), .word_sec(i_sec),
    .tag_q(tag_q), .meta_tag(meta_tag), .meta_sec(meta_sec), .meta_vld(meta_vld)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_ICTRL: begin
        rd_mux[IOFF_W-1:0] = ioff;
        rd_mux[CTL_WINC]   = i_winc;
        rd_mux[CTL_RINC]   = i_rinc;
        rd_mux[CTL_SEC]    = i_sec;
      end
      REG_ITAG:  rd_mux[TAG_W-1:0] = tag_q;
      REG_IDATA: rd_mux = i_word;
      REG_IMETA: begin
        rd_mux[TAG_W-1:0] = meta_tag;
        rd_mux[META_SEC]  = meta_sec;
        rd_mux[META_VLD]  = meta_vld;
      end
      REG_DCTRL: begin
        rd_mux[DOFF_W-1:0] = doff;
        rd_mux[CTL_WINC]   = d_winc;
        rd_mux[CTL_RINC]   = d_rinc;
        rd_mux[CTL_SEC]    = d_sec;
      end
      REG_DDATA: rd_mux = d_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{req_wdata[31:CTL_SEC+1], req_wdata[15:DOFF_W], req_wdata[1:0]};
endmodule

// File: rtl/pio_mem_port_chk.sv
module pio_mem_port_chk #(
  parameter int IOFF_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [2:0]        req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [IOFF_W-1:0] ioff,
  input logic              i_winc,
  input logic              i_rinc
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R9: no request taken while a response waits
  a_r9_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9: response held until taken
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R3: instruction data write with increment moves offset by one word
  a_r3_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == 3'd2 && i_winc) |=> ((ioff - $past(ioff)) == IOFF_W'(4)));

  // R4: instruction data read without increment keeps offset
  a_r4_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == 3'd2 && !i_rinc) |=> $stable(ioff));

  // R10: unmapped reads answer zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr > 3'd5) |=> (rsp_valid && rsp_rdata == 32'd0));
endmodule

bind pio_mem_port pio_mem_port_chk #(.IOFF_W(IOFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .ioff(ioff),
  .i_winc(i_winc), .i_rinc(i_rinc)
);

// File: tb/tb_pio_mem_port.sv
module tb_pio_mem_port;
  localparam int CLK_PERIOD = 10;
  localparam int IMEM_BYTES = 2048;
  localparam int DMEM_BYTES = 1024;
  localparam int BLOCKS     = IMEM_BYTES / 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [2:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_mem_port #(.IMEM_BYTES(IMEM_BYTES), .DMEM_BYTES(DMEM_BYTES),
                 .BLOCK_BYTES(256), .TAG_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // bench model
  logic [31:0] im [IMEM_BYTES/4];
  logic [31:0] dm [DMEM_BYTES/4];
  logic [15:0] mtag [BLOCKS];
  bit msec [BLOCKS];
  bit mvld [BLOCKS];
  int ioff = 0, doff = 0;
  bit iwi = 0, iri = 0, isec = 0, dwi = 0, dri = 0, armed = 0;
  logic [15:0] tagreg = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(int off, bit wi, bit ri, bit sec);
    return (32'(sec) << 18) | (32'(ri) << 17) | (32'(wi) << 16) | 32'(off & 16'hffff);
  endfunction

  function automatic logic [31:0] meta_word(int b);
    return (32'(mvld[b]) << 31) | (32'(msec[b]) << 16) | 32'(mtag[b]);
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic i_ctrl(input int off, input bit wi, input bit ri, input bit sec);
    bus_wr(3'd0, ctrl_word(off, wi, ri, sec));
    ioff = off & (IMEM_BYTES - 4); iwi = wi; iri = ri; isec = sec;
  endtask

  task automatic d_ctrl(input int off, input bit wi, input bit ri, input bit sec);
    bus_wr(3'd4, ctrl_word(off, wi, ri, sec));
    doff = off & (DMEM_BYTES - 4); dwi = wi; dri = ri;
  endtask

  task automatic i_tag(input logic [15:0] t);
    bus_wr(3'd1, {16'h0, t});
    tagreg = t; armed = 1;
  endtask

  task automatic i_wr(input logic [31:0] w);
    bus_wr(3'd2, w);
    im[ioff/4] = w;
    if (armed) begin
      mtag[ioff/256] = tagreg; msec[ioff/256] = isec; mvld[ioff/256] = 1; armed = 0;
    end
    if (iwi) ioff = (ioff + 4) % IMEM_BYTES;
  endtask

  task automatic d_wr(input logic [31:0] w);
    bus_wr(3'd5, w);
    dm[doff/4] = w;
    if (dwi) doff = (doff + 4) % DMEM_BYTES;
  endtask

  task automatic i_rd(input string req);
    logic [31:0] d;
    bus_rd(3'd2, d);
    check(req, d, im[ioff/4]);
    if (iri) ioff = (ioff + 4) % IMEM_BYTES;
  endtask

  task automatic d_rd(input string req);
    logic [31:0] d;
    bus_rd(3'd5, d);
    check(req, d, dm[doff/4]);
    if (dri) doff = (doff + 4) % DMEM_BYTES;
  endtask

  task automatic ictrl_chk(input string req);
    logic [31:0] d;
    bus_rd(3'd0, d);
    check(req, d, ctrl_word(ioff, iwi, iri, isec));
  endtask

  task automatic dctrl_chk(input string req);
    logic [31:0] d;
    bus_rd(3'd4, d);
    check(req, d, ctrl_word(doff, dwi, dri, 1'b0));
  endtask

  task automatic meta_chk(input int b, input string req);
    logic [31:0] d;
    i_ctrl(b * 256, 0, 0, 0);
    bus_rd(3'd3, d);
    check(req, d, meta_word(b));
  endtask

  task automatic load_blocks(input int base, input int nblk, input bit sec);
    i_ctrl(base, 1, 0, sec);
    for (int n = 0; n < nblk; n++) begin
      i_tag(16'((base >> 8) + n));
      for (int k = 0; k < 64; k++) i_wr($urandom);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements) actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, held;
    void'($urandom(32'd1234));
    for (int b = 0; b < BLOCKS; b++) begin mtag[b] = '0; msec[b] = 0; mvld[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    ictrl_chk("R1 ictrl");
    dctrl_chk("R1 dctrl");
    bus_rd(3'd3, d); check("R1 meta", d, 32'd0);

    // R2 control fields, low bits and high offset bits dropped
    i_ctrl(16'h1237, 1, 0, 1);
    ictrl_chk("R2 ictrl readback");

    // R3 R6 multi-block secure load, then non-secure load that wraps (R5)
    load_blocks(32'h100, 3, 1'b1);
    ictrl_chk("R3 offset after secure load");
    load_blocks(32'h600, 2, 1'b0);
    ictrl_chk("R5 offset wrapped to 0");

    // R4 read back with increment
    i_ctrl(32'h100, 0, 1, 0);
    for (int k = 0; k < 192; k++) i_rd("R4 secure region word");
    i_ctrl(32'h600, 0, 1, 0);
    for (int k = 0; k < 128; k++) i_rd("R4 upper region word");
    ictrl_chk("R5 read offset wrapped");

    // R7 per-block metadata (tags 1..3 secure, 6..7 not, rest invalid)
    for (int b = 0; b < BLOCKS; b++) meta_chk(b, "R7 block meta");

    // R6 tag without data changes nothing; next data write captures once
    i_tag(16'h0055);
    meta_chk(1, "R6 meta untouched by tag write");
    i_ctrl(32'h310, 1, 0, 1);
    i_wr(32'hcafe0001);
    i_wr(32'hcafe0002);
    i_ctrl(32'h100, 1, 0, 0);
    i_wr(32'hcafe0003);
    meta_chk(3, "R6 captured block 3");
    meta_chk(1, "R6 later write left block 1");

    // R3 no write increment: same word overwritten
    i_ctrl(32'h40, 0, 0, 0);
    i_wr(32'h11111111);
    i_wr(32'h22222222);
    ictrl_chk("R3 offset held");
    // R4 no read increment
    i_rd("R4 repeated read");
    i_rd("R4 repeated read");
    ictrl_chk("R4 offset held");

    // R8 data port: no secure bit, wrap (R5), independent offsets
    i_ctrl(32'h80, 0, 0, 1);
    d_ctrl(DMEM_BYTES - 4, 1, 0, 1);
    dctrl_chk("R8 dctrl secure reads 0");
    d_wr(32'hd0d0d0d0);
    d_wr(32'he1e1e1e1);
    dctrl_chk("R5 data offset wrapped");
    ictrl_chk("R8 instruction offset unmoved");
    d_ctrl(32'h80, 1, 0, 0);
    for (int k = 0; k < 32; k++) d_wr($urandom);
    d_ctrl(DMEM_BYTES - 4, 0, 1, 0);
    for (int k = 0; k < 34; k++) d_rd("R4 data word");
    ictrl_chk("R8 instruction offset after data reads");

    // R10 unmapped and read-only writes
    bus_wr(3'd7, 32'hffffffff);
    bus_wr(3'd6, 32'hffffffff);
    bus_wr(3'd3, 32'hffffffff);
    ictrl_chk("R10 ictrl unchanged");
    dctrl_chk("R10 dctrl unchanged");
    bus_rd(3'd7, d); check("R10 read addr 7", d, 32'd0);
    bus_rd(3'd6, d); check("R10 read addr 6", d, 32'd0);
    meta_chk(2, "R10 meta unchanged");

    // R9 back-pressure on the response
    i_ctrl(32'h104, 0, 0, 0);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 3'd2;
    @(negedge clk);
    req_valid = 0;
    held = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      check("R9 rsp_valid held", 32'(rsp_valid), 32'd1);
      check("R9 req_ready low", 32'(req_ready), 32'd0);
      check("R9 data stable", rsp_rdata, held);
      @(negedge clk);
    end
    check("R9 held data value", held, im[32'h104/4]);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check("R9 rsp released", 32'(rsp_valid), 32'd0);
    check("R9 ready again", 32'(req_ready), 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule